// File: doc/BRIEF.md
# Cell Rate Timer Parameter Calculator

This block turns a requested cell rate into the settings of a two-stage rate timer: a preload value p from 1 to 16 and a power-of-two divider exponent d from 0 to 14. The resulting cell rate is base / (p · 2^d). The base rate comes from a board-select input. The block is sequential. A start pulse latches the request. The block then finds the smallest usable exponent, divides with rounding by the selected mode, and computes the rate that the chosen setting really achieves. A one-cycle done pulse presents the encoded timer word, the achieved rate and an error flag.

A tolerance option runs the calculation first with round-to-nearest. It keeps that result when the achieved rate lies within plus or minus a given tolerance of the request. Otherwise it runs the calculation again with the requested rounding mode. All divisions use one shared restoring divider inside the block, so a request takes roughly one to four divider passes.

Top module: `rate_timer_calc`

## Requirements
- R1: A start with a requested rate of zero finishes on the next cycle with done and err high.
- R2: The exponent d is the smallest value in 0..14 for which base ≤ rate · 2^(4+d).
- R3: The preload is base / (rate · 2^d), rounded by round_mode:
  - 0 or 3 rounds to nearest (half the divisor is added before the integer divide).
  - 1 takes the ceiling, which gives a lower or equal rate.
  - 2 takes the floor, which gives a higher or equal rate.
- R4: At d = 0, a preload that computes to zero becomes 1 in modes 0, 1 and 3. In mode 2 it is an error.
- R5: If no d up to 14 meets the bound, the result is p = 16 and d = 14. Mode 1 reports an error instead.
- R6: cfg_word[7:4] holds d and cfg_word[3:0] holds p − 1.
- R7: rate_actual equals ceil(base / (p · 2^d)) for the returned setting.
- R8: With tol_en high, the round-to-nearest result is returned when rate − tol ≤ actual ≤ rate + tol, compared without wrap-around. Otherwise the block returns the result of the requested mode, including its error.
- R9: board_sel = 0 selects a base of 4,000,000 and board_sel = 1 selects a base of 5,000,000.
- R10: done is high for exactly one cycle per accepted request. A start while busy is high is ignored.
- R11: When err is high, cfg_word and rate_actual are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only when idle |
| rate_req | input | 32 | Requested cell rate |
| round_mode | input | 2 | 0/3 nearest, 1 ceiling, 2 floor |
| tol_en | input | 1 | Enable the nearest-first tolerance attempt |
| tol | input | 32 | Allowed distance of the nearest result from the request |
| board_sel | input | 1 | Selects the base rate |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Request could not be met |
| cfg_word | output | 8 | Encoded exponent and preload |
| rate_actual | output | 32 | Rate achieved by cfg_word |

## Verification
The assertions check several properties on every cycle:
- Every divider result satisfies q · den ≤ num < (q + 1) · den, and no division is ever started with a zero divisor.
- done never lasts longer than a cycle.
- A zero-rate request finishes at once with an error.
- Any successful result carries an exponent of at most 14 and a non-zero achieved rate.

The specific rounding outcomes cannot be seen from single cycles, so only the bench scenarios show them. These include the saturation and forced-preload corners, the tolerance boundary at exactly the distance of the nearest result, the base-rate selection, and the rejection of a start that arrives while busy.

// File: rtl/rate_calc_pkg.sv
package rate_calc_pkg;

    localparam int RATE_W = 32;
    localparam int PEXP   = 4;
    localparam int MAXD   = 14;
    localparam int EXP_W  = 4;
    localparam int PRE_W  = 4;
    localparam int WORD_W = EXP_W + PRE_W;
    localparam int DIV_W  = 48;
    localparam int SRCH_W = RATE_W + PEXP + MAXD;
    localparam int PMAX   = 1 << PEXP;

    typedef enum logic [1:0] {
        RND_NEAR  = 2'd0,
        RND_CEIL  = 2'd1,
        RND_FLOOR = 2'd2,
        RND_NEAR2 = 2'd3
    } round_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PRE   = 2'd2,
        ST_ACT   = 2'd3
    } calc_state_e;

    typedef struct packed {
        logic               err;
        logic [WORD_W-1:0]  word;
        logic [RATE_W-1:0]  actual;
    } calc_result_t;

    function automatic round_e norm_mode(input logic [1:0] m);
        return (m == RND_NEAR2) ? RND_NEAR : round_e'(m);
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input logic [EXP_W-1:0] d,
                                                    input logic [PEXP:0]    p);
        logic [PEXP:0] pm1;
        pm1 = p - 1'b1;
        return {d, pm1[PRE_W-1:0]};
    endfunction

endpackage

// File: rtl/rate_exp_search.sv
module rate_exp_search
    import rate_calc_pkg::*;
(
    input  logic [RATE_W-1:0] rate,
    input  logic [RATE_W-1:0] base,
    output logic              found,
    output logic [EXP_W-1:0]  dexp
);
    logic [MAXD:0] hit;

    genvar k;
    generate
        for (k = 0; k <= MAXD; k++) begin : g_cmp
            logic [SRCH_W-1:0] scaled;
            assign scaled = SRCH_W'(rate) << (PEXP + k);
            assign hit[k] = scaled >= SRCH_W'(base);
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        dexp  = '0;
        for (int i = MAXD; i >= 0; i--) begin
            if (hit[i]) begin
                found = 1'b1;
                dexp  = EXP_W'(i);
            end
        end
    end
endmodule

// File: rtl/rate_div.sv
module rate_div #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);
    localparam int W2 = 2 * W;

    logic [W:0]    rem;
    logic [W-1:0]  q_sh;
    logic [W-1:0]  num_q, den_q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    trial;

    assign trial = {rem[W-1:0], q_sh[W-1]};
    assign quo   = q_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            q_sh  <= '0;
            num_q <= '0;
            den_q <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_sh  <= num;
                num_q <= num;
                den_q <= den;
                rem   <= '0;
                cnt   <= CW'(W);
                run   <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, den_q}) begin
                    rem  <= trial - {1'b0, den_q};
                    q_sh <= {q_sh[W-2:0], 1'b1};
                end else begin
                    rem  <= trial;
                    q_sh <= {q_sh[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    logic [W2-1:0] prod_lo, prod_hi;
    assign prod_lo = W2'(quo) * W2'(den_q);
    assign prod_hi = prod_lo + W2'(den_q);

    // R3 / R7: every quotient is the exact floor of num / den
    p_quo_exact_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (prod_lo <= W2'(num_q)) && (W2'(num_q) < prod_hi));

    // R3: divisor is never zero when a division starts
    p_den_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        start |-> (den != '0));
endmodule

// File: rtl/rate_timer_calc.sv
module rate_timer_calc
    import rate_calc_pkg::*;
#(
    parameter logic [31:0] BASE_LO = 32'd4_000_000,
    parameter logic [31:0] BASE_HI = 32'd5_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] rate_req,
    input  logic [1:0]  round_mode,
    input  logic        tol_en,
    input  logic [31:0] tol,
    input  logic        board_sel,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [7:0]  cfg_word,
    output logic [31:0] rate_actual
);
    calc_state_e       state;
    logic [RATE_W-1:0] rate_q, tol_q, base_q;
    round_e            mode_q, pass_mode;
    logic              tolen_q, first_pass;
    logic [EXP_W-1:0]  d_q;
    logic [PEXP:0]     p_q;
    calc_result_t      res_q;

    logic              srch_found;
    logic [EXP_W-1:0]  srch_d;

    logic              div_start, div_done;
    logic [DIV_W-1:0]  div_num, div_den, div_quo;

    logic [PEXP:0]     p_sel;
    logic              p_bad;
    logic [DIV_W-1:0]  scaled_rate;
    logic [DIV_W-1:0]  act_den;
    logic              within_tol;

    rate_exp_search u_search (
        .rate  (rate_q),
        .base  (base_q),
        .found (srch_found),
        .dexp  (srch_d)
    );

    rate_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // preload selection from the first quotient
    always_comb begin
        p_sel = '0;
        p_bad = 1'b0;
        if (div_quo == '0) begin
            if (d_q == '0 && pass_mode != RND_FLOOR) p_sel = (PEXP+1)'(1);
            else                                     p_bad = 1'b1;
        end else if (div_quo > DIV_W'(PMAX)) begin
            p_bad = 1'b1;
        end else begin
            p_sel = div_quo[PEXP:0];
        end
    end

    assign scaled_rate = DIV_W'(rate_q) << srch_d;

    // divider operand selection
    always_comb begin
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        act_den   = '0;
        case (state)
            ST_SETUP: begin
                div_start = 1'b1;
                if (!srch_found) begin
                    act_den = DIV_W'(PMAX) << MAXD;
                    div_den = act_den;
                    div_num = DIV_W'(base_q) + act_den - 1'b1;
                    div_start = (pass_mode != RND_CEIL);
                end else begin
                    div_den = scaled_rate;
                    case (pass_mode)
                        RND_CEIL:  div_num = DIV_W'(base_q) + scaled_rate - 1'b1;
                        RND_FLOOR: div_num = DIV_W'(base_q);
                        default:   div_num = DIV_W'(base_q) + (scaled_rate >> 1);
                    endcase
                end
            end
            ST_PRE: begin
                act_den   = DIV_W'(p_sel) << d_q;
                div_den   = act_den;
                div_num   = DIV_W'(base_q) + act_den - 1'b1;
                div_start = div_done && !p_bad;
            end
            default: ;
        endcase
    end

    always_comb begin
        logic [RATE_W:0] a_ext, r_ext, t_ext;
        a_ext = {1'b0, div_quo[RATE_W-1:0]};
        r_ext = {1'b0, rate_q};
        t_ext = {1'b0, tol_q};
        within_tol = (a_ext + t_ext >= r_ext) && (a_ext <= r_ext + t_ext);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            rate_q     <= '0;
            tol_q      <= '0;
            base_q     <= '0;
            mode_q     <= RND_NEAR;
            pass_mode  <= RND_NEAR;
            tolen_q    <= 1'b0;
            first_pass <= 1'b0;
            d_q        <= '0;
            p_q        <= '0;
            res_q      <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        rate_q     <= rate_req;
                        tol_q      <= tol;
                        base_q     <= board_sel ? BASE_HI : BASE_LO;
                        mode_q     <= norm_mode(round_mode);
                        tolen_q    <= tol_en;
                        first_pass <= 1'b1;
                        pass_mode  <= tol_en ? RND_NEAR : norm_mode(round_mode);
                        if (rate_req == '0) begin
                            res_q <= '{err: 1'b1, word: '0, actual: '0};
                            done  <= 1'b1;
                        end else begin
                            state <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP: begin
                    if (!srch_found) begin
                        if (pass_mode == RND_CEIL) begin
                            res_q <= '{err: 1'b1, word: '0, actual: '0};
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            d_q   <= EXP_W'(MAXD);
                            p_q   <= (PEXP+1)'(PMAX);
                            state <= ST_ACT;
                        end
                    end else begin
                        d_q   <= srch_d;
                        state <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (div_done) begin
                        if (p_bad) begin
                            res_q <= '{err: 1'b1, word: '0, actual: '0};
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            p_q   <= p_sel;
                            state <= ST_ACT;
                        end
                    end
                end
                ST_ACT: begin
                    if (div_done) begin
                        if (first_pass && tolen_q && !within_tol) begin
                            first_pass <= 1'b0;
                            pass_mode  <= mode_q;
                            state      <= ST_SETUP;
                        end else begin
                            res_q <= '{err: 1'b0, word: pack_word(d_q, p_q),
                                       actual: div_quo[RATE_W-1:0]};
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign err         = res_q.err;
    assign cfg_word    = res_q.word;
    assign rate_actual = res_q.actual;

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1: zero rate accepted while idle ends at once with an error
    p_zero_rate_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && rate_req == '0) |=> (done && err));

    // R6: a good result never carries an exponent beyond 14
    p_exp_range_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (cfg_word[7:4] <= 4'(MAXD)));

    // R7: a good result always reports a non-zero achieved rate
    p_actual_pos_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (rate_actual != '0));
endmodule

// File: tb/rate_timer_calc_test.sv
module rate_timer_calc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] rate_req = '0;
    logic [1:0]  round_mode = '0;
    logic        tol_en = 1'b0;
    logic [31:0] tol = '0;
    logic        board_sel = 1'b0;
    logic        busy, done, err;
    logic [7:0]  cfg_word;
    logic [31:0] rate_actual;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    rate_timer_calc uut (
        .clk(clk), .rst(rst), .start(start), .rate_req(rate_req),
        .round_mode(round_mode), .tol_en(tol_en), .tol(tol),
        .board_sel(board_sel), .busy(busy), .done(done), .err(err),
        .cfg_word(cfg_word), .rate_actual(rate_actual)
    );

    typedef struct packed {
        logic [31:0] rate;
        logic [1:0]  mode;
        logic        board;
        logic        ten;
        logic [31:0] tolv;
        logic [7:0]  word;
        logic [31:0] act;
        logic        err;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{32'd4000000,   2'd0, 1'b0, 1'b0, 32'd0,  8'h00, 32'd4000000, 1'b0, 8'd3},  // R3 p=1
        '{32'd250000,    2'd0, 1'b0, 1'b0, 32'd0,  8'h0F, 32'd250000,  1'b0, 8'd6},  // R6 p=16 d=0
        '{32'd1000,      2'd0, 1'b0, 1'b0, 32'd0,  8'h8F, 32'd977,     1'b0, 8'd2},  // R2 d=8
        '{32'd1000,      2'd1, 1'b0, 1'b0, 32'd0,  8'h8F, 32'd977,     1'b0, 8'd3},  // R3 ceil
        '{32'd1000,      2'd2, 1'b0, 1'b0, 32'd0,  8'h8E, 32'd1042,    1'b0, 8'd3},  // R3 floor
        '{32'd10,        2'd0, 1'b0, 1'b0, 32'd0,  8'hEF, 32'd16,      1'b0, 8'd5},  // R5 saturate
        '{32'd10,        2'd1, 1'b0, 1'b0, 32'd0,  8'h00, 32'd0,       1'b1, 8'd5},  // R5 ceil error
        '{32'd10,        2'd2, 1'b0, 1'b0, 32'd0,  8'hEF, 32'd16,      1'b0, 8'd5},  // R5 floor saturate
        '{32'd8000000,   2'd2, 1'b0, 1'b0, 32'd0,  8'h00, 32'd0,       1'b1, 8'd4},  // R4 floor zero
        '{32'd100000000, 2'd0, 1'b0, 1'b0, 32'd0,  8'h00, 32'd4000000, 1'b0, 8'd4},  // R4 forced 1
        '{32'd100000000, 2'd1, 1'b0, 1'b0, 32'd0,  8'h00, 32'd4000000, 1'b0, 8'd4},  // R4 ceil
        '{32'd1000,      2'd0, 1'b1, 1'b0, 32'd0,  8'h99, 32'd977,     1'b0, 8'd9},  // R9 high base
        '{32'd300000,    2'd1, 1'b0, 1'b0, 32'd0,  8'h0D, 32'd285715,  1'b0, 8'd3},  // R3 ceil d=0
        '{32'd300000,    2'd0, 1'b0, 1'b0, 32'd0,  8'h0C, 32'd307693,  1'b0, 8'd7},  // R7 ceil actual
        '{32'd200000,    2'd0, 1'b0, 1'b0, 32'd0,  8'h19, 32'd200000,  1'b0, 8'd2},  // R2 d=1
        '{32'd1000,      2'd2, 1'b0, 1'b1, 32'd30, 8'h8F, 32'd977,     1'b0, 8'd8},  // R8 accept
        '{32'd1000,      2'd2, 1'b0, 1'b1, 32'd23, 8'h8F, 32'd977,     1'b0, 8'd8},  // R8 edge accept
        '{32'd1000,      2'd2, 1'b0, 1'b1, 32'd22, 8'h8E, 32'd1042,    1'b0, 8'd8},  // R8 edge reject
        '{32'd0,         2'd0, 1'b0, 1'b0, 32'd0,  8'h00, 32'd0,       1'b1, 8'd1},  // R1 zero rate
        '{32'd300000,    2'd3, 1'b0, 1'b0, 32'd0,  8'h0C, 32'd307693,  1'b0, 8'd3},  // R3 mode 3
        '{32'd5000000,   2'd0, 1'b1, 1'b0, 32'd0,  8'h00, 32'd5000000, 1'b0, 8'd9},  // R9 base 5M
        '{32'd10,        2'd1, 1'b0, 1'b1, 32'd0,  8'h00, 32'd0,       1'b1, 8'd11}  // R8/R11 retry error
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic issue(input logic [31:0] r, input logic [1:0] m, input logic b,
                         input logic te, input logic [31:0] tv);
        @(negedge clk);
        rate_req = r; round_mode = m; board_sel = b; tol_en = te; tol = tv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = done;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            seen = done;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                summary();
            end
        end
    end

    initial begin
        bit seen;
        int dones;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R10, R11)
        check(!busy && !done, "R10", "reset busy/done", {busy, done}, 0);
        check(!err && cfg_word == 0 && rate_actual == 0, "R11", "reset outputs",
              rate_actual, 0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", VEC[v].req, v);
            issue(VEC[v].rate, VEC[v].mode, VEC[v].board, VEC[v].ten, VEC[v].tolv);
            wait_done(seen);
            check(seen, tag, "done seen", seen, 1);
            check(err == VEC[v].err, tag, "err", err, VEC[v].err);
            check(cfg_word == VEC[v].word, tag, "cfg_word", cfg_word, VEC[v].word);
            check(rate_actual == VEC[v].act, tag, "rate_actual", rate_actual, VEC[v].act);
            @(negedge clk);
            check(!done, "R10", "done one cycle", done, 0);
        end

        // R1: zero rate completes on the very next cycle
        @(negedge clk);
        rate_req = 0; round_mode = 0; tol_en = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done && err, "R1", "zero rate next-cycle done/err", {done, err}, 3);

        // R10: start during a long calculation is ignored
        issue(32'd10, 2'd0, 1'b0, 1'b0, 32'd0);
        repeat (5) @(negedge clk);
        check(busy, "R10", "busy during calc", busy, 1);
        rate_req = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R10", "busy start not accepted", done, 0);
        dones = 0;
        for (int i = 0; i < 1000; i++) begin
            if (done) begin
                dones++;
                check(!err && cfg_word == 8'hEF && rate_actual == 16, "R10",
                      "first request result kept", rate_actual, 16);
            end
            @(negedge clk);
        end
        check(dones == 1, "R10", "done count", dones, 1);
        check(!busy, "R10", "idle after finish", busy, 0);

        summary();
    end
endmodule